// File: doc/BRIEF.md
# Prescaled Integer Clock Divider with Clean Output Gating

This block turns a master clock, already picked from an internal or external reference, into a slower output clock. The path is a small prescaler (divide by 1, 2 or 4) followed by an integer divider whose divisor is a 9-bit code plus two. A full-bypass setting sends the master clock straight to the output. The enable pin is asynchronous. It stops the output without shortening a high pulse, and it restarts the output with the same phase every time.

The configuration pins are meant to be tied off or driven from static storage. They are sampled on every clock edge while reset is active, and they are ignored once reset is released. The block has no streaming data path. Every pin is a plain control or clock signal, so there is no valid/ready handshake and no back-pressure.

Top module: `pdg_top`

## Requirements
- R1: The divider divisor N equals `div_code + 2`. With a prescale of one, the output period is N master cycles, from 2 up to 513.
- R2: When the prescaler is in use, `psc_half = 0` divides by 4 and `psc_half = 1` divides by 2. The output period is then prescale times N master cycles.
- R3: `psc_skip = 1` sets the prescale to one, and `psc_half` then has no effect.
- R4: `ext_ref = 1` sets the prescale to one whatever `psc_skip` and `psc_half` are, so the output is the master clock divided by N.
- R5: `full_skip = 1` makes `clk_out` high during the high phase of `clk` and low during its low phase while enabled. This holds for either value of `ext_ref`, and `div_code` and the prescaler bits have no effect.
- R6: In divided mode each period starts with the high phase. The high phase lasts prescale × floor(N/2) master cycles and the low phase lasts the rest.
- R7: If `en` goes low while `clk_out` is low, `clk_out` stays low until `en` returns high.
- R8: If `en` goes low while `clk_out` is high, the high phase runs its full length before `clk_out` falls and then stays low.
- R9: After `en` goes high, `clk_out` rises on the third rising clock edge that samples `en` high. This delay is the same on every restart.
- R10: In full-bypass mode, deasserting `en` forces `clk_out` low starting at a falling edge of `clk`, and it stays low.
- R11: Configuration pins are captured while `rst_n` is low. Changes made while `rst_n` is high do not affect `clk_out` until the next reset.
- R12: `clk_out` is low during reset and stays low until the block is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, already selected from its reference |
| rst_n | input | 1 | Active-low reset; configuration is captured while low |
| en | input | 1 | Asynchronous output enable, active high |
| div_code | input | 9 | Divider code; divisor is code + 2 |
| psc_half | input | 1 | Prescaler ratio: 0 = divide by 4, 1 = divide by 2 |
| psc_skip | input | 1 | 1 = bypass the prescaler |
| full_skip | input | 1 | 1 = route the master clock directly to the output |
| ext_ref | input | 1 | 1 = master clock comes from the external reference |
| clk_out | output | 1 | Divided or bypassed output clock |

## Verification
The hardest state to reach from the pins is an enable drop that lands inside a high phase after the two-flop synchronizer delay. The output has to survive that drop and finish its full high time. The bench reaches it by releasing `en` on the same sample at which the output first goes high, using a divisor whose high phase is longer than the synchronizer delay. That shows the pulse is not cut short. A second drop placed in the low phase, and a restart afterwards, show the hold behaviour and the fixed restart delay.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
  localparam int unsigned CODE_W  = 9;
  localparam int unsigned RATIO_W = 3;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              psc_half;
    logic              psc_skip;
    logic              full_skip;
    logic              ext_ref;
  } cfg_t;

  // prescale actually applied in divided mode: 1, 2 or 4
  function automatic logic [RATIO_W-1:0] psc_ratio(cfg_t c);
    if (c.ext_ref || c.psc_skip) return RATIO_W'(1);
    else if (c.psc_half)         return RATIO_W'(2);
    else                         return RATIO_W'(4);
  endfunction
endpackage

// File: rtl/pdg_en_sync.sv
module pdg_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_async,
  output logic en_s
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], en_async};
  end

  assign en_s = sh[STAGES-1];
endmodule

// File: rtl/pdg_psc.sv
module pdg_psc #(
  parameter int unsigned RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  localparam int unsigned CW = RATIO_W - 1;

  logic [CW-1:0] pcnt;
  logic [CW-1:0] plast;

  assign plast = CW'(ratio - 1'b1);

  // while held, park on the last count so the first running edge ticks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt <= '0;
    else if (!run)           pcnt <= plast;
    else if (pcnt == plast)  pcnt <= '0;
    else                     pcnt <= pcnt + 1'b1;
  end

  assign tick = run && (pcnt == plast);

  // R2
  psc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= plast);
endmodule

// File: rtl/pdg_ndiv.sv
module pdg_ndiv #(
  parameter int unsigned CODE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              div_out
);
  localparam int unsigned DW = CODE_W + 1;

  logic [DW-1:0] nlast, half, cnt, cnt_nx;

  assign nlast = DW'(code) + DW'(1);
  assign half  = (DW'(code) + DW'(2)) >> 1;

  always_comb cnt_nx = (cnt == nlast) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_out <= 1'b0;
    end else if (!run) begin
      cnt     <= nlast;
      div_out <= 1'b0;
    end else if (tick) begin
      cnt     <= cnt_nx;
      div_out <= (cnt_nx < half);
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= nlast);
  // R6
  rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_out) |-> (cnt == '0));
endmodule

// File: rtl/pdg_top.sv
module pdg_top
  import pdg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] div_code,
  input  logic              psc_half,
  input  logic              psc_skip,
  input  logic              full_skip,
  input  logic              ext_ref,
  output logic              clk_out
);
  cfg_t cfg_q;
  logic en_s, run, tick, div_out, gate_q;

  // R11: configuration sampled only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '{code: div_code, psc_half: psc_half, psc_skip: psc_skip,
                           full_skip: full_skip, ext_ref: ext_ref};
  end

  pdg_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .en_async(en), .en_s(en_s));

  // keep running while enabled, or until a started high phase ends
  assign run = !cfg_q.full_skip && (en_s || div_out);

  pdg_psc #(.RATIO_W(RATIO_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .ratio(psc_ratio(cfg_q)), .tick(tick));

  pdg_ndiv #(.CODE_W(CODE_W)) u_ndiv (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .code(cfg_q.code),
    .div_out(div_out));

  // bypass gate changes only while clk is low, so no runt pulse
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= en_s && cfg_q.full_skip;
  end

  assign clk_out = cfg_q.full_skip ? (clk & gate_q) : div_out;

  // R7
  held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s && !div_out) |=> !div_out);
  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg_q));
  // R8
  no_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_out) |-> $past(run));
endmodule

// File: tb/pdg_top_bench.sv
module pdg_top_bench;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [8:0] div_code = '0;
  logic psc_half = 1'b0, psc_skip = 1'b0, full_skip = 1'b0, ext_ref = 1'b0;
  logic clk_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pdg_top u_pdg_top (.clk(clk), .rst_n(rst_n), .en(en), .div_code(div_code),
    .psc_half(psc_half), .psc_skip(psc_skip), .full_skip(full_skip),
    .ext_ref(ext_ref), .clk_out(clk_out));

  typedef struct packed { int code; bit half; bit skip; bit ext; int hi; int lo; } vec_t;
  // expected hi = P*floor(N/2), lo = P*N - hi, with N = code+2 and P from R2..R4
  localparam vec_t VT [8] = '{
    '{0,   1'b0, 1'b0, 1'b0, 4,   4},
    '{1,   1'b1, 1'b0, 1'b0, 2,   4},
    '{5,   1'b0, 1'b1, 1'b0, 3,   4},
    '{3,   1'b0, 1'b0, 1'b1, 2,   3},
    '{511, 1'b1, 1'b0, 1'b1, 256, 257},
    '{10,  1'b0, 1'b0, 1'b0, 24,  24},
    '{2,   1'b1, 1'b1, 1'b0, 2,   2},
    '{4,   1'b1, 1'b0, 1'b0, 6,   6}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int code, input bit h, input bit s, input bit f, input bit x);
    @(negedge clk);
    en = 1'b0; rst_n = 1'b0;
    div_code = 9'(code); psc_half = h; psc_skip = s; full_skip = f; ext_ref = x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // called at a negedge with clk_out low; waits for a rise, then times high and low
  task automatic measure(output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    while (!clk_out && guard < 5000) begin @(negedge clk); guard++; end
    while (clk_out && hi < 5000) begin hi++; @(negedge clk); end
    while (!clk_out && lo < 5000) begin lo++; @(negedge clk); end
  endtask

  task automatic count_low(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_out) highs++;
    end
  endtask

  initial begin
    int hi, lo, hs;
    // R12: reset state
    do_reset(5, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R12 out low in reset", int'(clk_out), 0);
    rst_n = 1'b1;
    count_low(10, hs);
    chk("R12 low before enable", hs, 0);

    // table walk: R1 R2 R3 R4 R6
    for (int v = 0; v < 8; v++) begin
      do_reset(VT[v].code, VT[v].half, VT[v].skip, 1'b0, VT[v].ext);
      @(negedge clk); en = 1'b1;
      measure(hi, lo);
      chk($sformatf("R6 high time vec%0d", v), hi, VT[v].hi);
      chk($sformatf("R1 R2 R3 R4 low time vec%0d", v), lo, VT[v].lo);
    end

    // R9: restart latency, then R8: drop inside high phase (N=12, hi 6)
    do_reset(10, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk); en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 low after two edges", int'(clk_out), 0);
    @(negedge clk);
    chk("R9 high on third edge", int'(clk_out), 1);
    en = 1'b0;
    hi = 0;
    while (clk_out && hi < 100) begin hi++; @(negedge clk); end
    chk("R8 full high kept", hi, 6);
    count_low(40, hs);
    chk("R8 stays low", hs, 0);

    // R7: drop inside low phase, then R9 again
    en = 1'b1;
    while (!clk_out) @(negedge clk);
    while (clk_out) @(negedge clk);
    en = 1'b0;
    count_low(40, hs);
    chk("R7 held low", hs, 0);
    en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 restart low", int'(clk_out), 0);
    @(negedge clk);
    chk("R9 restart high", int'(clk_out), 1);

    // R11: config change while running is ignored until reset
    while (clk_out) @(negedge clk);
    div_code = 9'd0; psc_skip = 1'b1;
    measure(hi, lo);
    chk("R11 ignored hi", hi, 6);
    chk("R11 ignored lo", lo, 6);
    do_reset(0, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk); en = 1'b1;
    measure(hi, lo);
    chk("R11 applied after reset hi", hi, 1);
    chk("R11 applied after reset lo", lo, 1);

    // R5 full bypass, internal then external
    for (int x = 0; x < 2; x++) begin
      do_reset(7, 1'b0, 1'b0, 1'b1, x[0]);
      @(negedge clk); en = 1'b1;
      repeat (5) @(negedge clk);
      @(posedge clk); #1;
      chk($sformatf("R5 high phase ext=%0d", x), int'(clk_out), 1);
      @(negedge clk); #1;
      chk($sformatf("R5 low phase ext=%0d", x), int'(clk_out), 0);
    end
    // R10: disable in bypass
    @(negedge clk); en = 1'b0;
    repeat (4) @(negedge clk);
    hs = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1; if (clk_out) hs++;
    end
    chk("R10 bypass gated low", hs, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule